// File: doc/BRIEF.md
# Converter Result Byte Pair with Read Interlock

This block holds the most recent 10-bit result from an analog-to-digital converter and presents it to an 8-bit bus as two byte registers. The high byte sits at address 0 and the low byte at address 1. A mode input selects the format. In 8-bit truncated form, the low byte carries the eight upper result bits and the high byte reads zero. In right-justified form, the high byte carries the two upper result bits in its bits 1..0, and the low byte carries the eight lower bits.

Each result arrives on a valid/ready stream. The sink never applies back-pressure: `cv_ready` is held high, and every beat with `cv_valid` high is consumed in its cycle. A consumed beat is either stored or discarded. When a beat is discarded, `drop_pulse` goes high for one cycle.

In right-justified mode, software reads the high byte first. That read locks the pair, so the two bytes stay from the same conversion. Results that complete while the pair is locked are discarded. Reading the low byte releases the lock. The bus has no write path, so the registers are read-only by construction. Read data is registered and appears one clock after the read strobe.

Top module: `adc_pair_top`

## Requirements
- R1: After reset, reads at address 0 and address 1 both return 0x00. `rd_data` is 0x00 and `drop_pulse` is 0.
- R2: With `mode_rj`=0 (truncated), every completion loads result[9:2] into the low byte and 0x00 into the high byte. A prior high-byte read does not block this.
- R3: With `mode_rj`=1 (right-justified), a stored completion loads {6'b0, result[9:8]} into the high byte (address 0) and result[7:0] into the low byte (address 1).
- R4: In right-justified mode, a high-byte read sets the lock on that clock edge. While the lock is set, completions are discarded and both bytes keep their values.
- R5: A low-byte read clears the lock on that clock edge. The next completion after that edge is stored.
- R6: A completion in the same cycle as the low-byte read that clears the lock is discarded.
- R7: In right-justified mode, a completion in the same cycle as a high-byte read is discarded. That read returns the old high byte.
- R8: A change of `mode_rj` clears the lock. Both bytes keep their contents until the next stored completion.
- R9: `drop_pulse` is high for exactly one cycle, in the cycle after each discarded completion, and is low at all other times.
- R10: `rd_data` shows the addressed byte one clock after `rd_en`. It holds that value while `rd_en` is low.
- R11: `cv_ready` is always 1. No completion beat is ever stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_rj | input | 1 | 1 = right-justified with interlock, 0 = 8-bit truncated |
| cv_valid | input | 1 | Conversion-complete beat valid |
| cv_ready | output | 1 | Always 1; the sink never stalls |
| cv_data | input | 10 | Converter result |
| rd_en | input | 1 | Bus read strobe |
| rd_addr | input | 1 | 0 = high byte, 1 = low byte |
| rd_data | output | 8 | Registered read data |
| drop_pulse | output | 1 | One-cycle pulse per discarded result |

## Verification
Two collisions matter in this block. The first is a completion landing in the same cycle as a high-byte read. The second is a completion landing in the same cycle as the low-byte read that releases the lock. The bench provokes each one by driving `cv_valid` and `rd_en` on the same clock edge. It then judges the outcome three ways:
- the read returns the older byte;
- exactly one `drop_pulse` is counted;
- a follow-up read pair still shows the pre-collision result until a fresh completion is stored.

// File: rtl/adc_pair_pkg.sv
package adc_pair_pkg;
  localparam int RES_W = 10;
  localparam int BUS_W = 8;
  localparam int HI_W  = RES_W - BUS_W;

  typedef enum logic {ADDR_HI = 1'b0, ADDR_LO = 1'b1} pair_addr_e;
endpackage

// File: rtl/adc_pair_capture.sv
module adc_pair_capture
  import adc_pair_pkg::*;
#(
  parameter int RW = RES_W,
  parameter int BW = BUS_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_rj,
  input  logic          cv_valid,
  input  logic [RW-1:0] cv_data,
  input  logic          hi_rd,
  input  logic          lo_rd,
  output logic [RW-BW-1:0] hi_q,
  output logic [BW-1:0] lo_q,
  output logic          lock_q,
  output logic          mode_q,
  output logic          drop_q
);
  localparam int HW = RW - BW;

  logic mode_chg;
  logic drop;
  logic store;
  logic lock_d;

  assign mode_chg = mode_rj ^ mode_q;
  assign drop     = cv_valid & mode_rj & (lock_q | hi_rd);
  assign store    = cv_valid & ~drop;

  always_comb begin
    lock_d = lock_q;
    if (mode_chg || !mode_rj) lock_d = 1'b0;
    else if (lo_rd)           lock_d = 1'b0;
    else if (hi_rd)           lock_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q   <= '0;
      lo_q   <= '0;
      lock_q <= 1'b0;
      mode_q <= 1'b0;
      drop_q <= 1'b0;
    end else begin
      lock_q <= lock_d;
      mode_q <= mode_rj;
      drop_q <= drop;
      if (store) begin
        if (mode_rj) begin
          hi_q <= cv_data[RW-1 -: HW];
          lo_q <= cv_data[BW-1:0];
        end else begin
          hi_q <= '0;
          lo_q <= cv_data[RW-1 -: BW];
        end
      end
    end
  end
endmodule

// File: rtl/adc_pair_rdport.sv
module adc_pair_rdport
  import adc_pair_pkg::*;
#(
  parameter int BW = BUS_W,
  parameter int HW = HI_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic          rd_addr,
  input  logic [HW-1:0] hi_q,
  input  logic [BW-1:0] lo_q,
  output logic [BW-1:0] rd_data
);
  logic [BW-1:0] hi_byte;

  generate
    if (BW > HW) begin : g_pad
      assign hi_byte = {{(BW-HW){1'b0}}, hi_q};
    end else begin : g_nopad
      assign hi_byte = hi_q[BW-1:0];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= (rd_addr == ADDR_LO) ? lo_q : hi_byte;
  end
endmodule

// File: rtl/adc_pair_top.sv
module adc_pair_top
  import adc_pair_pkg::*;
#(
  parameter int RW = RES_W,
  parameter int BW = BUS_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_rj,
  input  logic          cv_valid,
  output logic          cv_ready,
  input  logic [RW-1:0] cv_data,
  input  logic          rd_en,
  input  logic          rd_addr,
  output logic [BW-1:0] rd_data,
  output logic          drop_pulse
);
  localparam int HW = RW - BW;

  logic [HW-1:0] hi_q;
  logic [BW-1:0] lo_q;
  logic          lock_q;
  logic          mode_q;
  logic          hi_rd;
  logic          lo_rd;

  assign cv_ready = 1'b1;
  assign hi_rd    = rd_en & (rd_addr == ADDR_HI);
  assign lo_rd    = rd_en & (rd_addr == ADDR_LO);

  adc_pair_capture #(.RW(RW), .BW(BW)) u_cap (
    .clk(clk), .rst_n(rst_n), .mode_rj(mode_rj),
    .cv_valid(cv_valid), .cv_data(cv_data),
    .hi_rd(hi_rd), .lo_rd(lo_rd),
    .hi_q(hi_q), .lo_q(lo_q), .lock_q(lock_q), .mode_q(mode_q),
    .drop_q(drop_pulse)
  );

  adc_pair_rdport #(.BW(BW), .HW(HW)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
    .hi_q(hi_q), .lo_q(lo_q), .rd_data(rd_data)
  );
endmodule

// File: rtl/adc_pair_chk.sv
module adc_pair_chk #(
  parameter int RW = 10,
  parameter int BW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mode_rj,
  input logic          cv_valid,
  input logic [RW-1:0] cv_data,
  input logic          rd_en,
  input logic          rd_addr,
  input logic          drop_pulse,
  input logic          lock_q,
  input logic          mode_q,
  input logic [RW-BW-1:0] hi_q,
  input logic [BW-1:0] lo_q
);
  // R4
  hi_read_locks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && !rd_addr && mode_rj && mode_q |=> lock_q);

  // R5
  lo_read_unlocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && rd_addr |=> !lock_q);

  // R4
  locked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q && mode_rj |=> $stable(lo_q) && $stable(hi_q));

  // R9
  locked_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cv_valid && mode_rj && lock_q |=> drop_pulse);

  // R9
  no_spurious_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cv_valid && mode_rj) |=> !drop_pulse);

  // R2
  trunc_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cv_valid && !mode_rj |=> lo_q == $past(cv_data[RW-1 -: BW]) && hi_q == '0);

  // R8
  mode_change_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_rj != mode_q |=> !lock_q);
endmodule

bind adc_pair_top adc_pair_chk #(.RW(RW), .BW(BW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_rj(mode_rj), .cv_valid(cv_valid),
  .cv_data(cv_data), .rd_en(rd_en), .rd_addr(rd_addr),
  .drop_pulse(drop_pulse), .lock_q(lock_q), .mode_q(mode_q),
  .hi_q(hi_q), .lo_q(lo_q)
);

// File: tb/adc_pair_top_tb.sv
`timescale 1ns/1ps
module adc_pair_top_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_rj = 1'b0;
  logic       cv_valid = 1'b0;
  logic       cv_ready;
  logic [9:0] cv_data = '0;
  logic       rd_en = 1'b0;
  logic       rd_addr = 1'b0;
  logic [7:0] rd_data;
  logic       drop_pulse;

  int n_cmp = 0;
  int n_bad = 0;
  int drops_seen = 0;
  logic rd_seen = 1'b0;
  logic done = 1'b0;

  typedef struct { logic [7:0] exp; string tag; } item_t;
  item_t sb[$];

  always #2 clk = ~clk;

  adc_pair_top u_dut (
    .clk(clk), .rst_n(rst_n), .mode_rj(mode_rj), .cv_valid(cv_valid),
    .cv_ready(cv_ready), .cv_data(cv_data), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_data(rd_data), .drop_pulse(drop_pulse)
  );

  always @(posedge clk) rd_seen <= rd_en;

  // monitor: pops one expected byte per read, counts drop pulses
  always @(negedge clk) begin
    if (rst_n && drop_pulse) drops_seen++;
    if (rst_n && rd_seen && sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      n_cmp++;
      if (rd_data !== it.exp) begin
        n_bad++;
        $display("FAIL %s: rd_data=%02h expected=%02h", it.tag, rd_data, it.exp);
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one cycle; optional read and optional completion on the same edge
  task automatic cyc(input bit rd, input bit addr, input logic [7:0] exp, input string tag,
                     input bit cv, input logic [9:0] d);
    rd_en = rd; rd_addr = addr; cv_valid = cv; cv_data = d;
    if (rd) sb.push_back('{exp, tag});
    @(negedge clk);
    rd_en = 1'b0; cv_valid = 1'b0;
  endtask

  task automatic rd(input bit addr, input logic [7:0] exp, input string tag);
    cyc(1'b1, addr, exp, tag, 1'b0, '0);
  endtask

  task automatic conv(input logic [9:0] d);
    cyc(1'b0, 1'b0, 8'h00, "", 1'b1, d);
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(rd_data == 8'h00, "R1 rd_data reset", rd_data, 0);
    check(drop_pulse == 1'b0, "R1 drop reset", drop_pulse, 0);
    rst_n = 1'b1;
    idle();
    rd(1'b0, 8'h00, "R1 high after reset");
    rd(1'b1, 8'h00, "R1 low after reset");
    check(cv_ready == 1'b1, "R11 ready", cv_ready, 1);

    // truncated mode
    conv(10'h2B7);
    rd(1'b1, 8'hAD, "R2 trunc low");
    rd(1'b0, 8'h00, "R2 trunc high zero");
    conv(10'h3FF);
    rd(1'b1, 8'hFF, "R2 no interlock");
    idle(); idle();
    check(rd_data == 8'hFF, "R10 hold", rd_data, 8'hFF);

    // right-justified
    mode_rj = 1'b1;
    idle();
    conv(10'h1A5);
    rd(1'b0, 8'h01, "R3 rj high");
    conv(10'h2C3);
    idle();
    check(drops_seen == 1, "R9 one drop", drops_seen, 1);
    rd(1'b1, 8'hA5, "R4 locked low kept");
    conv(10'h2C3);
    rd(1'b0, 8'h02, "R5 high after unlock");
    rd(1'b1, 8'hC3, "R5 low after unlock");
    check(cv_ready == 1'b1, "R11 ready rj", cv_ready, 1);

    // R6 collision: completion with unlocking low read
    rd(1'b0, 8'h02, "R6 lock");
    cyc(1'b1, 1'b1, 8'hC3, "R6 collide low", 1'b1, 10'h155);
    rd(1'b0, 8'h02, "R6 high unchanged");
    rd(1'b1, 8'hC3, "R6 low unchanged");
    idle();
    check(drops_seen == 2, "R6 drop count", drops_seen, 2);
    conv(10'h155);
    rd(1'b0, 8'h01, "R6 next high");
    rd(1'b1, 8'h55, "R6 next low");

    // R7 collision: completion with high read
    cyc(1'b1, 1'b0, 8'h01, "R7 collide high", 1'b1, 10'h0F0);
    rd(1'b1, 8'h55, "R7 low unchanged");
    idle();
    check(drops_seen == 3, "R7 drop count", drops_seen, 3);

    // R8 mode change clears lock, keeps contents
    rd(1'b0, 8'h01, "R8 lock");
    mode_rj = 1'b0;
    idle();
    rd(1'b0, 8'h01, "R8 contents kept");
    mode_rj = 1'b1;
    idle();
    conv(10'h3E7);
    rd(1'b0, 8'h03, "R8 stored after change");
    rd(1'b1, 8'hE7, "R8 low after change");
    idle(); idle();
    check(drops_seen == 3, "R9 no extra drops", drops_seen, 3);
    check(sb.size() == 0, "R10 all reads seen", sb.size(), 0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule